// File: doc/BRIEF.md
# Partitioned Saturating Vector Adder-Subtracter

This block adds or subtracts two 64-bit operands as a packed vector of independent lanes. A format select treats each operand either as eight unsigned 8-bit lanes or as four signed 16-bit lanes in two's complement. No carry crosses a lane boundary. The block is built from 8-bit slices. In the 16-bit format, each pair of slices is linked by a carry. In the 8-bit format the pair is split.

An operation select picks addition or subtraction. A mode select picks the result handling. In saturating mode, a lane result that falls outside the lane's range is clamped to the nearest limit. In wrapping mode the truncated sum is kept. In both modes an overflow flag is reported for each lane. The result and the flags are captured into an output register on a cycle where the input valid is high. A decoder upstream drives the three selects directly.

Top module: `simd_addsub`

## Requirements
- R1: With fmt_half=0, op_sub=0 and sat_en=0, each byte lane result[8i+7:8i] equals (a lane + b lane) mod 256. A carry out of one byte never changes the byte above it.
- R2: With fmt_half=0, op_sub=1 and sat_en=0, each byte lane result equals (a lane − b lane) mod 256.
- R3: With fmt_half=0, ovf[i] flags byte lane i. On add it is set when the unsigned sum exceeds 255. On subtract it is set when the a lane is less than the b lane. The flag is reported in both modes.
- R4: With fmt_half=0 and sat_en=1, a flagged byte lane reads 255 on add and 0 on subtract.
- R5: With fmt_half=1, lane k occupies result[16k+15:16k] and holds (a lane ± b lane) mod 65536 in wrapping mode. The carry passes between the two bytes of a lane. ovf[k] flags lane k and ovf[7:4] read 0.
- R6: With fmt_half=1, ovf[k] is set when the exact signed result lies outside −32768..32767. With sat_en=1, a flagged lane reads 32767 (0x7FFF) if the exact result is positive and −32768 (0x8000) if it is negative.
- R7: result, ovf and out_valid update on the rising edge after a cycle with in_valid=1. out_valid is 1 exactly in the cycle that follows an input cycle with in_valid=1.
- R8: While in_valid=0, result and ovf keep their values whatever a, b and the selects do.
- R9: While rst_n=0 (active low, asynchronous), result, ovf and out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture enable for the output register |
| fmt_half | input | 1 | 0: eight unsigned bytes, 1: four signed halfwords |
| op_sub | input | 1 | 0: a+b, 1: a−b |
| sat_en | input | 1 | 1: saturate, 0: wrap |
| a | input | 64 | First operand vector |
| b | input | 64 | Second operand vector |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 64 | Registered lane results |
| ovf | output | 8 | Registered overflow flags, one per lane |

## Verification
Every output of this block is due one rising edge after the cycle that presents the operands. No later edge produces a result. The bench applies operands just after a falling edge and compares the outputs at the next falling edge, so exactly one rising edge lies between stimulus and comparison. Its reference model holds the values that should be in the register and updates them only on cycles with in_valid high. Cycles with in_valid low change the operands, and the comparison one edge later shows that the held values have not moved.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic {
    FMT_BYTE = 1'b0,
    FMT_HALF = 1'b1
  } lane_fmt_e;

  // Unsigned lane overflow: carry out on add, missing carry (borrow) on subtract.
  function automatic logic unsigned_ovf(input logic carry, input logic sub);
    return sub ? ~carry : carry;
  endfunction

  // Signed lane overflow from the sign bits of both operands and the raw result.
  function automatic logic signed_ovf(input logic sa, input logic sb,
                                      input logic sr, input logic sub);
    logic same_in;
    same_in = sub ? (sa != sb) : (sa == sb);
    return same_in && (sr != sa);
  endfunction

endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               sub_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  logic [SLICE_W-1:0] b_eff;
  logic [SLICE_W:0]   total;

  assign b_eff  = b_i ^ {SLICE_W{sub_i}};
  assign total  = {1'b0, a_i} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin_i};
  assign sum_o  = total[SLICE_W-1:0];
  assign cout_o = total[SLICE_W];
endmodule

// File: rtl/simd_lane_pair.sv
module simd_lane_pair #(
  parameter int SLICE_W = 8
) (
  input  logic [2*SLICE_W-1:0] a_i,
  input  logic [2*SLICE_W-1:0] b_i,
  input  logic                 sub_i,
  input  logic                 half_i,
  output logic [2*SLICE_W-1:0] sum_o,
  output logic [1:0]           cout_o
);
  logic lo_cout;
  logic hi_cout;
  logic hi_cin;

  simd_slice_add #(.SLICE_W(SLICE_W)) u_lo (
    .a_i   (a_i[SLICE_W-1:0]),
    .b_i   (b_i[SLICE_W-1:0]),
    .sub_i (sub_i),
    .cin_i (sub_i),
    .sum_o (sum_o[SLICE_W-1:0]),
    .cout_o(lo_cout)
  );

  // Carry cut: the upper slice takes the lower carry only when the pair is one lane.
  assign hi_cin = half_i ? lo_cout : sub_i;

  simd_slice_add #(.SLICE_W(SLICE_W)) u_hi (
    .a_i   (a_i[2*SLICE_W-1:SLICE_W]),
    .b_i   (b_i[2*SLICE_W-1:SLICE_W]),
    .sub_i (sub_i),
    .cin_i (hi_cin),
    .sum_o (sum_o[2*SLICE_W-1:SLICE_W]),
    .cout_o(hi_cout)
  );

  assign cout_o = {hi_cout, lo_cout};
endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp
  import simd_addsub_pkg::*;
#(
  parameter int SLICE_W = 8,
  parameter int N_SLICE = 8
) (
  input  logic [N_SLICE*SLICE_W-1:0] raw_i,
  input  logic [N_SLICE-1:0]         cout_i,
  input  logic [N_SLICE/2-1:0]       a_sign_i,
  input  logic [N_SLICE/2-1:0]       b_sign_i,
  input  logic                       half_i,
  input  logic                       sub_i,
  input  logic                       sat_i,
  output logic [N_SLICE*SLICE_W-1:0] res_o,
  output logic [N_SLICE-1:0]         ovf_o
);
  localparam int N_HALF = N_SLICE / 2;
  localparam int HALF_W = 2 * SLICE_W;
  localparam int VEC_W  = N_SLICE * SLICE_W;

  logic [VEC_W-1:0]   byte_res;
  logic [VEC_W-1:0]   half_res;
  logic [N_SLICE-1:0] byte_ovf;
  logic [N_HALF-1:0]  half_ovf;

  for (genvar i = 0; i < N_SLICE; i++) begin : g_byte
    assign byte_ovf[i] = unsigned_ovf(cout_i[i], sub_i);
    assign byte_res[i*SLICE_W +: SLICE_W] =
      (sat_i && byte_ovf[i]) ? (sub_i ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}})
                             : raw_i[i*SLICE_W +: SLICE_W];
  end

  for (genvar k = 0; k < N_HALF; k++) begin : g_half
    logic sr;
    assign sr          = raw_i[k*HALF_W + HALF_W-1];
    assign half_ovf[k] = signed_ovf(a_sign_i[k], b_sign_i[k], sr, sub_i);
    assign half_res[k*HALF_W +: HALF_W] =
      !(sat_i && half_ovf[k]) ? raw_i[k*HALF_W +: HALF_W] :
      a_sign_i[k]             ? {1'b1, {HALF_W-1{1'b0}}}
                              : {1'b0, {HALF_W-1{1'b1}}};
  end

  assign res_o = half_i ? half_res : byte_res;
  assign ovf_o = half_i ? {{(N_SLICE-N_HALF){1'b0}}, half_ovf} : byte_ovf;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_addsub_pkg::*;
#(
  parameter int VEC_W   = 64,
  parameter int SLICE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       fmt_half,
  input  logic                       op_sub,
  input  logic                       sat_en,
  input  logic [VEC_W-1:0]           a,
  input  logic [VEC_W-1:0]           b,
  output logic                       out_valid,
  output logic [VEC_W-1:0]           result,
  output logic [VEC_W/SLICE_W-1:0]   ovf
);
  localparam int N_SLICE = VEC_W / SLICE_W;
  localparam int N_HALF  = N_SLICE / 2;
  localparam int HALF_W  = 2 * SLICE_W;

  lane_fmt_e          fmt;
  logic [VEC_W-1:0]   raw_sum;
  logic [N_SLICE-1:0] slice_cout;
  logic [N_HALF-1:0]  a_sign;
  logic [N_HALF-1:0]  b_sign;
  logic [VEC_W-1:0]   next_res;
  logic [N_SLICE-1:0] next_ovf;

  assign fmt = lane_fmt_e'(fmt_half);

  for (genvar k = 0; k < N_HALF; k++) begin : g_pair
    simd_lane_pair #(.SLICE_W(SLICE_W)) u_pair (
      .a_i   (a[k*HALF_W +: HALF_W]),
      .b_i   (b[k*HALF_W +: HALF_W]),
      .sub_i (op_sub),
      .half_i(fmt == FMT_HALF),
      .sum_o (raw_sum[k*HALF_W +: HALF_W]),
      .cout_o(slice_cout[2*k +: 2])
    );
    assign a_sign[k] = a[k*HALF_W + HALF_W-1];
    assign b_sign[k] = b[k*HALF_W + HALF_W-1];
  end

  simd_lane_clamp #(.SLICE_W(SLICE_W), .N_SLICE(N_SLICE)) u_clamp (
    .raw_i   (raw_sum),
    .cout_i  (slice_cout),
    .a_sign_i(a_sign),
    .b_sign_i(b_sign),
    .half_i  (fmt == FMT_HALF),
    .sub_i   (op_sub),
    .sat_i   (sat_en),
    .res_o   (next_res),
    .ovf_o   (next_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        ovf    <= next_ovf;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int VEC_W   = 64,
  parameter int SLICE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     fmt_half,
  input logic                     op_sub,
  input logic                     sat_en,
  input logic [VEC_W-1:0]         a,
  input logic [VEC_W-1:0]         b,
  input logic                     out_valid,
  input logic [VEC_W-1:0]         result,
  input logic [VEC_W/SLICE_W-1:0] ovf
);
  localparam int N_SLICE = VEC_W / SLICE_W;
  localparam int N_HALF  = N_SLICE / 2;
  localparam int HALF_W  = 2 * SLICE_W;

  p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ovf)));
  p_half_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_half) |=> (ovf[N_SLICE-1:N_HALF] == '0));

  for (genvar i = 0; i < N_SLICE; i++) begin : g_byte_chk
    p_wrap_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_half && !sat_en && !op_sub) |=>
      (result[i*SLICE_W +: SLICE_W] ==
       SLICE_W'($past(a[i*SLICE_W +: SLICE_W]) + $past(b[i*SLICE_W +: SLICE_W]))));
    p_wrap_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_half && !sat_en && op_sub) |=>
      (result[i*SLICE_W +: SLICE_W] ==
       SLICE_W'($past(a[i*SLICE_W +: SLICE_W]) - $past(b[i*SLICE_W +: SLICE_W]))));
    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_half && sat_en && !op_sub) |=>
      (!ovf[i] || result[i*SLICE_W +: SLICE_W] == {SLICE_W{1'b1}}));
    p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_half && sat_en && op_sub) |=>
      (!ovf[i] || result[i*SLICE_W +: SLICE_W] == {SLICE_W{1'b0}}));
  end

  for (genvar k = 0; k < N_HALF; k++) begin : g_half_chk
    p_half_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt_half && sat_en) |=>
      (!ovf[k] ||
       result[k*HALF_W +: HALF_W] == {1'b0, {HALF_W-1{1'b1}}} ||
       result[k*HALF_W +: HALF_W] == {1'b1, {HALF_W-1{1'b0}}}));
  end
endmodule

bind simd_addsub simd_addsub_chk #(.VEC_W(VEC_W), .SLICE_W(SLICE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .fmt_half (fmt_half),
  .op_sub   (op_sub),
  .sat_en   (sat_en),
  .a        (a),
  .b        (b),
  .out_valid(out_valid),
  .result   (result),
  .ovf      (ovf)
);

// File: tb/simd_addsub_bench.sv
`timescale 1ns/1ps
module simd_addsub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        fmt_half = 1'b0;
  logic        op_sub = 1'b0;
  logic        sat_en = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  ovf;

  int n_checks = 0;
  int n_fails  = 0;

  // reference register state
  logic        exp_valid = 1'b0;
  logic [63:0] exp_res   = '0;
  logic [7:0]  exp_ovf   = '0;
  string       exp_tag   = "R9";

  always #10 clk = ~clk;

  simd_addsub u_simd_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_half(fmt_half),
    .op_sub(op_sub), .sat_en(sat_en), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  task automatic ref_calc(input logic fh, input logic sb, input logic st,
                          input logic [63:0] x, input logic [63:0] y,
                          output logic [63:0] r, output logic [7:0] f);
    r = '0;
    f = '0;
    if (!fh) begin
      for (int i = 0; i < 8; i++) begin
        int xa = int'(x[8*i +: 8]);
        int yb = int'(y[8*i +: 8]);
        int s  = sb ? xa - yb : xa + yb;
        logic o = (s < 0) || (s > 255);
        if (st && o) s = (s < 0) ? 0 : 255;
        f[i] = o;
        r[8*i +: 8] = s[7:0];
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        int xa = $signed(x[16*k +: 16]);
        int yb = $signed(y[16*k +: 16]);
        int s  = sb ? xa - yb : xa + yb;
        logic o = (s < -32768) || (s > 32767);
        if (st && o) s = (s < 0) ? -32768 : 32767;
        f[k] = o;
        r[16*k +: 16] = s[15:0];
      end
    end
  endtask

  task automatic compare();
    n_checks++;
    if (out_valid !== exp_valid || result !== exp_res || ovf !== exp_ovf) begin
      n_fails++;
      $display("FAIL %s: valid/result/ovf = %b/%h/%h expected %b/%h/%h",
               exp_tag, out_valid, result, ovf, exp_valid, exp_res, exp_ovf);
    end
  endtask

  // compare the outputs of the previous cycle, then present a new input cycle
  task automatic step(input logic v, input logic fh, input logic sb, input logic st,
                      input logic [63:0] x, input logic [63:0] y, input string tag);
    logic [63:0] r;
    logic [7:0]  f;
    @(negedge clk);
    compare();
    in_valid = v; fmt_half = fh; op_sub = sb; sat_en = st; a = x; b = y;
    exp_valid = v;
    if (v) begin
      ref_calc(fh, sb, st, x, y, r, f);
      exp_res = r;
      exp_ovf = f;
    end
    exp_tag = tag;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R9: reset state, checked while reset is held
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // byte lanes, wrapped add with carry cut between bytes (R1, R3)
    step(1, 0, 0, 0, 64'h00FF_01FF_7F80_1234, 64'h0001_FF01_0180_0101, "R1 R3");
    // byte lanes, wrapped subtract with borrow per lane (R2, R3)
    step(1, 0, 1, 0, 64'h0010_0100_FF00_8000, 64'h0001_0001_01FF_7F01, "R2 R3");
    // byte saturation on add and subtract (R4)
    step(1, 0, 0, 1, 64'hFF80_C801_FE00_7F10, 64'h0180_3901_0200_8020, "R4");
    step(1, 0, 1, 1, 64'h0010_0100_FF00_8000, 64'h0001_0001_01FF_7F01, "R4");
    // halfword lanes, carry crosses the byte inside a lane (R5)
    step(1, 1, 0, 0, 64'h00FF_7FFF_8000_FFFF, 64'h0001_0001_FFFF_0001, "R5");
    step(1, 1, 1, 0, 64'h0100_8000_7FFF_0000, 64'h0001_0001_FFFF_0001, "R5");
    // halfword signed saturation, both directions (R6)
    step(1, 1, 0, 1, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_BFFF, "R6");
    step(1, 1, 1, 1, 64'h8000_7FFF_0000_FFFF, 64'h0001_FFFF_8000_7FFF, "R6");
    // hold: invalid cycles with changing operands leave the register alone (R8)
    step(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    step(0, 1, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, "R8");
    // one-cycle latency and out_valid pulse (R7)
    step(1, 0, 0, 0, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202, "R7");
    step(0, 0, 0, 0, 64'h0, 64'h0, "R7");
    step(1, 1, 0, 0, 64'h0003_0003_0003_0003, 64'h0004_0004_0004_0004, "R7");
    // mixed patterns across every mode
    for (int n = 0; n < 400; n++) begin
      logic [3:0] m = 4'($urandom);
      string t = m[2] ? (m[0] ? "R6" : "R5") : (m[0] ? "R4" : (m[1] ? "R2" : "R1"));
      if (!m[3] && n[3]) t = "R8";
      step(m[3] || !n[3], m[2], m[1], m[0], {$urandom, $urandom}, {$urandom, $urandom}, t);
    end
    step(0, 0, 0, 0, 64'h0, 64'h0, "R7");
    // reset in the middle of operation (R9)
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    exp_valid = 1'b0; exp_res = '0; exp_ovf = '0; exp_tag = "R9";
    @(negedge clk);
    compare();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule